// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block steps one DMA parameter set through a transfer that has three nested levels. The smallest level is an array of contiguous bytes. Several arrays make a frame, and several frames make a block. For each array it issues one beat on a valid/ready output. The beat carries the read address, the write address and the byte count. A data mover downstream turns each beat into bus traffic.

The parameter sets sit in a small word-addressed memory that software fills through the parameter port. The sequencer always works on set 0. A sync-mode field in that set decides how much one trigger pulse moves: a single array, a whole frame, or the entire block. Progress is written back into set 0 between triggers, so a later trigger picks up where the earlier one stopped. When the final array of the block has been accepted, the block does three things: it pulses a completion strobe, it presents the set's completion code, and it overwrites set 0 with the set that the link field names. A link of all ones instead leaves a null set behind, and a trigger on a null set raises an error strobe.

Top module: `dma3d_seq`

## Requirements
- R1: Each output beat describes one array: `x_src` and `x_dst` are that array's start addresses, and `x_cnt` equals the array byte count (word 2 bits 15:0). While `x_valid` is high and `x_ready` is low, `x_valid`, `x_src`, `x_dst` and `x_cnt` hold their values.
- R2: Word 0 bits 1:0 choose the sync mode. With 0, one trigger moves one array. With 1, one trigger moves one frame, whose array count is word 2 bits 31:16. With 2, one trigger moves every remaining array of the block, whose frame count is word 7 bits 15:0.
- R3: Inside a frame, each side moves to its next array by adding its own signed 16-bit array index. The source index is word 4 bits 15:0 and the destination index is word 4 bits 31:16.
- R4: Word 0 bit 2 puts the source into constant-address mode and word 0 bit 3 does the same for the destination. In constant mode that address never changes.
- R5: At a frame boundary each side adds its own signed frame index: source in word 6 bits 15:0, destination in word 6 bits 31:16. In sync mode 0 the index is added to the start of the last array. In modes 1 and 2 it is added to the start of the frame just finished. The array count then reloads from word 5 bits 31:16.
- R6: A set occupies words 8*n to 8*n+7. Start addresses are in words 1 (source) and 3 (destination). When a set completes, the eight words of the set whose number is in word 5 bits 15:0 are copied over set 0. The result can be read back through `pm_rdata`.
- R7: A link value of 0xFFFF leaves set 0 null: every word is zero except word 5, which becomes 0x0000FFFF. A trigger on a set whose array count or frame count is zero produces no beat and pulses `err_o` for one cycle.
- R8: One cycle after the final beat of a set is accepted, `done_o` pulses for one cycle and `done_code` shows word 0 bits 15:8 of that set.
- R9: A trigger that arrives while beats are still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_we | input | 1 | Parameter memory write enable |
| pm_addr | input | $clog2(8*NSETS) | Parameter memory word address |
| pm_wdata | input | 32 | Parameter memory write data |
| pm_rdata | output | 32 | Parameter memory read data (combinational) |
| trig | input | 1 | Transfer trigger for set 0 |
| x_valid | output | 1 | Beat valid |
| x_ready | input | 1 | Beat accepted by the consumer |
| x_src | output | 32 | Source address of the array |
| x_dst | output | 32 | Destination address of the array |
| x_cnt | output | 16 | Byte count of the array |
| done_o | output | 1 | Set completion pulse |
| done_code | output | 8 | Completion code of the finished set |
| err_o | output | 1 | Trigger on a null or empty set |

## Verification
A trigger driven in one cycle is registered at the next edge. The first beat appears right after that edge, and `err_o` appears in the same cycle for an empty set. Each later beat follows the accepting edge by one cycle. `done_o` comes one cycle after the last accepting edge. A driver task works out every beat and completion code from the set contents and queues them. A monitor samples on the falling edge and pops one item for each accepted beat, each `done_o` pulse and each `err_o` pulse. This keeps every comparison tied to handshakes and not to fixed delays, so a pseudo-random `x_ready` pattern does not upset the order. Set contents after write-back and link reload are read through the parameter port once the sequencer has gone idle.

// File: rtl/dma3d_seq.sv
module dma3d_seq #(
  parameter int NSETS = 16,
  localparam int WORDS = NSETS * 8,
  localparam int PW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_we,
  input  logic [PW-1:0] pm_addr,
  input  logic [31:0]   pm_wdata,
  output logic [31:0]   pm_rdata,
  input  logic          trig,
  output logic          x_valid,
  input  logic          x_ready,
  output logic [31:0]   x_src,
  output logic [31:0]   x_dst,
  output logic [15:0]   x_cnt,
  output logic          done_o,
  output logic [7:0]    done_code,
  output logic          err_o
);

  logic [31:0] mem [WORDS];
  logic        run;
  logic [31:0] cs, cd, fs, fd;
  logic [15:0] b, c;

  wire [1:0]  sync  = mem[0][1:0];
  wire        src_k = mem[0][2];
  wire        dst_k = mem[0][3];
  wire [15:0] bcnt  = mem[2][31:16];
  wire [15:0] lnk   = mem[5][15:0];
  wire [15:0] brl   = mem[5][31:16];
  wire [15:0] ccnt  = mem[7][15:0];
  wire [31:0] sbi   = {{16{mem[4][15]}}, mem[4][15:0]};
  wire [31:0] dbi   = {{16{mem[4][31]}}, mem[4][31:16]};
  wire [31:0] sci   = {{16{mem[6][15]}}, mem[6][15:0]};
  wire [31:0] dci   = {{16{mem[6][31]}}, mem[6][31:16]};

  wire hs    = run & x_ready;
  wire lastb = (b == 16'd1);
  wire lastc = (c == 16'd1);
  wire fin   = lastb & lastc;
  wire endtr = (sync == 2'd0) | (lastb & ((sync == 2'd1) | lastc));

  wire [31:0] ns_fr = src_k ? cs : (((sync == 2'd0) ? cs : fs) + sci);
  wire [31:0] nd_fr = dst_k ? cd : (((sync == 2'd0) ? cd : fd) + dci);
  wire [31:0] nxs   = lastb ? ns_fr : (src_k ? cs : cs + sbi);
  wire [31:0] nxd   = lastb ? nd_fr : (dst_k ? cd : cd + dbi);
  wire [15:0] nb    = lastb ? brl : b - 16'd1;
  wire [15:0] nc    = lastb ? c - 16'd1 : c;

  assign pm_rdata = mem[pm_addr];
  assign x_valid  = run;
  assign x_src    = cs;
  assign x_dst    = cd;
  assign x_cnt    = mem[2][15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; done_o <= 1'b0; err_o <= 1'b0; done_code <= 8'd0;
      cs <= '0; cd <= '0; fs <= '0; fd <= '0; b <= '0; c <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (pm_we) mem[pm_addr] <= pm_wdata;
      if (!run && trig) begin
        if (bcnt == 16'd0 || ccnt == 16'd0) err_o <= 1'b1;
        else begin
          run <= 1'b1;
          cs <= mem[1]; cd <= mem[3]; fs <= mem[1]; fd <= mem[3];
          b <= bcnt; c <= ccnt;
        end
      end
      if (hs) begin
        cs <= nxs; cd <= nxd; b <= nb; c <= nc;
        if (lastb) begin fs <= ns_fr; fd <= nd_fr; end
        if (endtr) begin
          run <= 1'b0;
          if (fin) begin
            done_o    <= 1'b1;
            done_code <= mem[0][15:8];
            for (int k = 0; k < 8; k++) begin
              if (lnk == 16'hFFFF) mem[k] <= (k == 5) ? 32'h0000FFFF : 32'd0;
              else mem[k] <= mem[PW'({16'd0, lnk} * 32'd8 + 32'(k))];
            end
          end else begin
            mem[1] <= nxs;
            mem[3] <= nxd;
            mem[2][31:16] <= nb;
            mem[7][15:0]  <= nc;
          end
        end
      end
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && !x_ready) |=> (x_valid && $stable(x_src) && $stable(x_dst) && $stable(x_cnt)));

  // R4
  src_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_ready && src_k) |=> (!x_valid || $stable(x_src)));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !x_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(x_valid && x_ready));

endmodule

// File: tb/dma3d_seq_tb_top.sv
module dma3d_seq_tb_top;
  localparam int NSETS = 16;
  localparam int PW = $clog2(NSETS * 8);

  logic clk = 1'b0, rst_n = 1'b0, pm_we = 1'b0, trig = 1'b0, x_ready = 1'b1;
  logic [PW-1:0] pm_addr = '0;
  logic [31:0] pm_wdata = '0, pm_rdata, x_src, x_dst;
  logic [15:0] x_cnt;
  logic x_valid, done_o, err_o;
  logic [7:0] done_code;

  int tests = 0, fails = 0, err_exp = 0, err_seen = 0, cyc = 0;
  bit stall = 1'b0;
  logic [79:0] exp_q[$];
  logic [7:0]  code_q[$];
  logic [31:0] mir [NSETS*8];

  always #5 clk = ~clk;

  dma3d_seq #(.NSETS(NSETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata), .trig(trig), .x_valid(x_valid), .x_ready(x_ready),
    .x_src(x_src), .x_dst(x_dst), .x_cnt(x_cnt), .done_o(done_o),
    .done_code(done_code), .err_o(err_o));

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      x_ready = stall ? lf[0] : 1'b1;
    end
  end

  // monitor
  initial begin
    logic pv = 1'b0, pr = 1'b1;
    logic [79:0] pbeat = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (pv && !pr) check("R1 stall hold", {x_valid, x_src, x_dst, x_cnt}, {1'b1, pbeat[79:0]});
        if (x_valid && x_ready) begin
          if (exp_q.size() == 0) check("R9 unexpected beat", {x_src, x_dst, x_cnt}, '0);
          else check("R1/R2/R3/R5 beat", {x_src, x_dst, x_cnt}, exp_q.pop_front());
        end
        if (done_o) begin
          if (code_q.size() == 0) check("R8 unexpected done", 80'(done_code), 80'hFFFF);
          else check("R8 completion code", 80'(done_code), 80'(code_q.pop_front()));
        end
        if (err_o) err_seen++;
      end
      pv = x_valid; pr = x_ready; pbeat = {x_src, x_dst, x_cnt};
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    pm_we = 1'b1; pm_addr = PW'(a); pm_wdata = d; mir[a] = d;
    @(posedge clk); #1;
    pm_we = 1'b0;
  endtask

  task automatic wr_set(int n, logic [31:0] opt, logic [31:0] s, logic [15:0] a, logic [15:0] bb,
                        logic [31:0] d, logic [15:0] sbi, logic [15:0] dbi, logic [15:0] lk,
                        logic [15:0] rl, logic [15:0] sci, logic [15:0] dci, logic [15:0] cc);
    wr(n*8+0, opt); wr(n*8+1, s); wr(n*8+2, {bb, a}); wr(n*8+3, d);
    wr(n*8+4, {dbi, sbi}); wr(n*8+5, {rl, lk}); wr(n*8+6, {dci, sci}); wr(n*8+7, {16'd0, cc});
  endtask

  task automatic settle();
    while (exp_q.size() != 0 || code_q.size() != 0 || err_seen != err_exp || x_valid) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // driver: reference model of one trigger on set 0
  task automatic fire(bit extra_trig);
    logic [31:0] o = mir[0], s = mir[1], d = mir[3], fs, fd;
    int sy = int'(o[1:0]), bb = int'(mir[2][31:16]), cc = int'(mir[7][15:0]), rl = int'(mir[5][31:16]);
    int sbi = int'($signed(mir[4][15:0])), dbi = int'($signed(mir[4][31:16]));
    int sci = int'($signed(mir[6][15:0])), dci = int'($signed(mir[6][31:16]));
    int n, lk = int'(mir[5][15:0]);
    fs = s; fd = d;
    if (bb == 0 || cc == 0) err_exp++;
    else begin
      n = (sy == 0) ? 1 : (sy == 1) ? bb : bb * cc;
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({s, d, mir[2][15:0]});
        if (bb > 1) begin
          if (!o[2]) s = s + sbi;
          if (!o[3]) d = d + dbi;
          bb--;
        end else begin
          if (!o[2]) s = ((sy == 0) ? s : fs) + sci;
          if (!o[3]) d = ((sy == 0) ? d : fd) + dci;
          fs = s; fd = d; bb = rl; cc--;
        end
      end
      if (cc == 0) begin
        code_q.push_back(o[15:8]);
        for (int k = 0; k < 8; k++)
          mir[k] = (lk == 16'hFFFF) ? ((k == 5) ? 32'h0000FFFF : 32'd0) : mir[lk*8+k];
      end else begin
        mir[1] = s; mir[3] = d; mir[2][31:16] = 16'(bb); mir[7][15:0] = 16'(cc);
      end
    end
    @(posedge clk); #1; trig = 1'b1;
    @(posedge clk); #1; trig = 1'b0;
    if (extra_trig) begin
      repeat (2) @(posedge clk);
      #1; trig = 1'b1;
      @(posedge clk); #1; trig = 1'b0;
    end
    settle();
  endtask

  task automatic check_set0(string req);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1; pm_addr = PW'(k);
      @(negedge clk);
      check(req, 80'(pm_rdata), 80'(mir[k]));
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset done", 80'(done_o), 80'd0);
        check("R7 reset err", 80'(err_o), 80'd0);
        check("R1 reset valid", 80'(x_valid), 80'd0);
        #1 rst_n = 1'b1;
        // set 1: frame sync, reloads from set 2
        wr_set(1, 32'h0000_1101, 32'h2000, 16'd8, 16'd2, 32'h9000, 16'd8, 16'h10, 16'd2, 16'd2, 16'h40, 16'h40, 16'd2);
        // set 2: array sync, constant source, null link
        wr_set(2, 32'h0000_2204, 32'h3000, 16'd4, 16'd2, 32'hA000, 16'd4, 16'd4, 16'hFFFF, 16'd2, 16'd0, 16'h30, 16'd2);
        // set 0: block sync, negative destination frame index
        wr_set(0, 32'h0000_5A02, 32'h1000, 16'd16, 16'd3, 32'h8000, 16'h20, 16'h40, 16'd1, 16'd3, 16'h100, 16'hFFF0, 16'd2);
        fire(0);                          // R2 block, R3 indexes, R5 frame index from frame start
        check_set0("R6 link reload");
        stall = 1'b1;
        fire(0); fire(0);                 // R2 frame sync, R1 under stall
        check_set0("R6 link reload second");
        fire(0); fire(0);                 // R2 array sync, R4 constant source
        check_set0("R5 array write-back");
        fire(0); fire(0);                 // R5 reload of array count, then null
        check_set0("R7 null set");
        fire(0);                          // R7 trigger on null set
        check("R7 error pulses", 80'(err_seen), 80'(err_exp));
        // R4 constant destination with block sync, R9 trigger while busy
        wr_set(0, 32'h0000_3C0A, 32'h4000, 16'd2, 16'd3, 32'hB000, 16'h4, 16'h4, 16'd1, 16'd3, 16'h8, 16'h8, 16'd2);
        wr_set(1, 32'h0000_0002, 32'h5000, 16'd1, 16'd1, 32'h6000, 16'd0, 16'd0, 16'hFFFF, 16'd1, 16'd0, 16'd0, 16'd1);
        fire(1);
        check_set0("R6 reload after busy trigger");
        check("R9 queues drained", 80'(exp_q.size() + code_q.size()), 80'd0);
      end
      begin
        while (cyc < 100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule